// File: doc/BRIEF.md
# Five-Level Seven-Segment Space-Vector Sequencer

This block plays out one sampling period of space-vector modulation for a three-phase, five-level inverter. Once per period it captures three dwell times, given in clock ticks, together with the per-phase level states of two zero vectors and two active vectors. It then drives the three phase level codes through a mirrored seven-segment pattern. The pattern opens and closes on the first zero state, passes through both active vectors on the way in and on the way out, and holds the second zero state in the middle.

Software or an upstream stage works out the dwell times and the states of the current sector. This block only places them in time. The captured values are fixed for the whole period, so the inputs can change at any moment. A one-cycle pulse marks the first tick of each period. If a supplied state set would make any phase jump by more than one level, or would change two phases at one segment boundary, the block refuses that set. It then holds its outputs steady for the period and raises an error flag.

Top module: `svm7_sequencer`

## Requirements
- R1: Every phase output is a 3-bit level code: 0 = -2E, 1 = -E, 2 = 0, 3 = +E, 4 = +2E. Codes 5 to 7 are never driven. Each state input packs phase A in bits [2:0], phase B in bits [5:3] and phase C in bits [8:6], in the same code.
- R2: A period lasts exactly dwellA + dwellB + dwellZ clock ticks, or one tick if that sum is zero. `periodStart` is high for exactly one cycle, and that cycle is the one in which the first tick of the period is driven.
- R3: The segments run in the order Za, V1, V2, Zb, V2, V1, Za. Their durations are: each outer Za gets floor(dwellZ/4); the middle Zb gets dwellZ - 2*floor(dwellZ/4); the first V1 gets floor(dwellA/2) and the second V1 gets the rest of dwellA; V2 is split the same way from dwellB.
- R4: A segment whose duration is zero ticks never appears on the outputs, not even for one cycle.
- R5: Dwell times and states are captured only at a period boundary, on the tick after the last tick of the previous period. Input changes at any other time have no effect on the period in progress.
- R6: A captured set is invalid if any state holds a code above 4, or if two consecutive non-empty segments differ by more than one level in total over the three phases. For an invalid set, `seqError` is high for the whole period and all three outputs hold the levels driven on the previous tick. The period still lasts the length given by R2.
- R7: When all three dwell times are zero, the period is one tick long and drives state Za.
- R8: During reset, and until the first period is output, the levels are code 2 and `periodStart` and `seqError` are low. Each output reflects the sequence position one clock after that position is reached internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dwellA | input | DWELL_W | Dwell ticks of the first active vector (V1) |
| dwellB | input | DWELL_W | Dwell ticks of the second active vector (V2) |
| dwellZ | input | DWELL_W | Total dwell ticks of the zero states |
| stateZa | input | 9 | Outer zero state, three packed level codes |
| stateV1 | input | 9 | First active vector, three packed level codes |
| stateV2 | input | 9 | Second active vector, three packed level codes |
| stateZb | input | 9 | Middle zero state, three packed level codes |
| levelA | output | 3 | Phase A level code |
| levelB | output | 3 | Phase B level code |
| levelC | output | 3 | Phase C level code |
| periodStart | output | 1 | One-cycle marker on the first tick of a period |
| seqError | output | 1 | High for every tick of a period whose captured set was invalid |

## Verification
The assertions watch properties that must hold on every cycle:
- Outputs stay inside the five legal codes.
- Inside a period, one cycle never differs from the next by more than one level step.
- Outputs freeze while the error flag is high.
- The error flag changes only at a period start.
- Each start pulse follows a capture by exactly two cycles.

Only the bench scenarios can show the rest:
- The exact segment durations and rounding of odd dwell times.
- The skipping of empty segments.
- One-tick periods.
- That mid-period input changes are ignored.

The bench shows these by running a behavioural per-tick queue model beside the block.

// File: rtl/svm7_pkg.sv
package svm7_pkg;

  localparam int PHASES = 3;
  localparam int SEGS = 7;

  typedef logic [2:0] level_t;
  typedef level_t [PHASES-1:0] triple_t;

  localparam level_t LVL_ZERO = 3'd2;
  localparam level_t LVL_MAX = 3'd4;

  typedef struct packed {
    logic load;   // capture new period parameters
    logic emit;   // a sequence position is valid this cycle
    logic first;  // current position is the first tick of a period
  } strobe_t;

  // total level distance across the three phases
  function automatic logic [3:0] levelDist(triple_t x, triple_t y);
    logic [3:0] s;
    s = '0;
    for (int p = 0; p < PHASES; p++) begin
      if (x[p] > y[p]) s = s + 4'(x[p] - y[p]);
      else s = s + 4'(y[p] - x[p]);
    end
    return s;
  endfunction

endpackage

// File: rtl/svm7_ctrl.sv
module svm7_ctrl
  import svm7_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          atEnd,
  output strobe_t       strobe,
  output logic [CW-1:0] tick
);

  logic running;

  always_comb begin
    strobe.load  = !running || atEnd;
    strobe.emit  = running;
    strobe.first = running && (tick == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      tick    <= '0;
    end else begin
      running <= 1'b1;
      if (strobe.load) tick <= '0;
      else tick <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/svm7_datapath.sv
module svm7_datapath
  import svm7_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = DW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [CW-1:0] tick,
  input  logic [DW-1:0] dwellA,
  input  logic [DW-1:0] dwellB,
  input  logic [DW-1:0] dwellZ,
  input  triple_t       stZa,
  input  triple_t       stV1,
  input  triple_t       stV2,
  input  triple_t       stZb,
  output logic          atEnd,
  output triple_t       levelOut,
  output logic          startOut,
  output logic          errOut
);

  // candidate segment lengths and states from the inputs
  logic [DW-1:0] zEdge, zMid, aFirst, aSecond, bFirst, bSecond;
  logic [DW-1:0] candLen [SEGS];
  triple_t       candSt  [SEGS];
  logic [CW-1:0] candEnd [SEGS];
  logic [CW-1:0] candTotal;
  logic          codesOk, stepOk, candValid;

  always_comb begin
    zEdge   = dwellZ >> 2;
    zMid    = dwellZ - (zEdge << 1);
    aFirst  = dwellA >> 1;
    aSecond = dwellA - aFirst;
    bFirst  = dwellB >> 1;
    bSecond = dwellB - bFirst;
    candLen[0] = zEdge;  candSt[0] = stZa;
    candLen[1] = aFirst; candSt[1] = stV1;
    candLen[2] = bFirst; candSt[2] = stV2;
    candLen[3] = zMid;   candSt[3] = stZb;
    candLen[4] = bSecond; candSt[4] = stV2;
    candLen[5] = aSecond; candSt[5] = stV1;
    candLen[6] = zEdge;  candSt[6] = stZa;
    candTotal = CW'(dwellA) + CW'(dwellB) + CW'(dwellZ);
  end

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int k = 0; k < SEGS; k++) begin
      acc = acc + CW'(candLen[k]);
      candEnd[k] = acc;
    end
  end

  // per-phase code range check over the four distinct states
  logic [PHASES-1:0] phaseOk;
  for (genvar p = 0; p < PHASES; p++) begin : g_code
    assign phaseOk[p] = (stZa[p] <= LVL_MAX) && (stV1[p] <= LVL_MAX) &&
                        (stV2[p] <= LVL_MAX) && (stZb[p] <= LVL_MAX);
  end
  assign codesOk = &phaseOk;

  // transition rule between consecutive non-empty segments
  always_comb begin
    logic    haveLast;
    triple_t lastSt;
    haveLast = 1'b0;
    lastSt   = '0;
    stepOk   = 1'b1;
    for (int k = 0; k < SEGS; k++) begin
      if (candLen[k] != '0) begin
        if (haveLast && (levelDist(lastSt, candSt[k]) > 4'd1)) stepOk = 1'b0;
        lastSt   = candSt[k];
        haveLast = 1'b1;
      end
    end
  end
  assign candValid = codesOk && stepOk;

  // period registers
  logic [CW-1:0] endQ [SEGS];
  triple_t       stQ  [SEGS];
  logic [CW-1:0] lastTickQ;
  logic          errQ;
  triple_t       selLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SEGS; k++) begin
        endQ[k] <= '0;
        stQ[k]  <= {PHASES{LVL_ZERO}};
      end
      lastTickQ <= '0;
      errQ      <= 1'b0;
    end else if (strobe.load) begin
      for (int k = 0; k < SEGS; k++) begin
        endQ[k] <= candEnd[k];
        stQ[k]  <= candValid ? candSt[k] : selLevel;
      end
      lastTickQ <= (candTotal == '0) ? '0 : candTotal - 1'b1;
      errQ      <= !candValid;
    end
  end

  // segment select: first segment whose end lies beyond the tick
  always_comb begin
    logic found;
    found    = 1'b0;
    selLevel = stQ[0];
    for (int k = 0; k < SEGS; k++) begin
      if (!found && (tick < endQ[k])) begin
        selLevel = stQ[k];
        found    = 1'b1;
      end
    end
  end

  assign atEnd = (tick == lastTickQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelOut <= {PHASES{LVL_ZERO}};
      startOut <= 1'b0;
      errOut   <= 1'b0;
    end else if (strobe.emit) begin
      levelOut <= selLevel;
      startOut <= strobe.first;
      errOut   <= errQ;
    end else begin
      startOut <= 1'b0;
    end
  end

endmodule

// File: rtl/svm7_sequencer.sv
module svm7_sequencer
  import svm7_pkg::*;
#(
  parameter int DWELL_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DWELL_W-1:0] dwellA,
  input  logic [DWELL_W-1:0] dwellB,
  input  logic [DWELL_W-1:0] dwellZ,
  input  logic [8:0]         stateZa,
  input  logic [8:0]         stateV1,
  input  logic [8:0]         stateV2,
  input  logic [8:0]         stateZb,
  output logic [2:0]         levelA,
  output logic [2:0]         levelB,
  output logic [2:0]         levelC,
  output logic               periodStart,
  output logic               seqError
);

  localparam int CNT_W = DWELL_W + 2;

  strobe_t          strobe;
  logic [CNT_W-1:0] tick;
  logic             atEnd;
  triple_t          levelOut;

  svm7_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .atEnd  (atEnd),
    .strobe (strobe),
    .tick   (tick)
  );

  svm7_datapath #(.DW(DWELL_W), .CW(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tick     (tick),
    .dwellA   (dwellA),
    .dwellB   (dwellB),
    .dwellZ   (dwellZ),
    .stZa     (stateZa),
    .stV1     (stateV1),
    .stV2     (stateV2),
    .stZb     (stateZb),
    .atEnd    (atEnd),
    .levelOut (levelOut),
    .startOut (periodStart),
    .errOut   (seqError)
  );

  assign levelA = levelOut[0];
  assign levelB = levelOut[1];
  assign levelC = levelOut[2];

endmodule

// File: rtl/svm7_checker.sv
module svm7_checker
  import svm7_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] levelA,
  input logic [2:0] levelB,
  input logic [2:0] levelC,
  input logic       periodStart,
  input logic       seqError,
  input logic       loadStb
);

  triple_t nowLv;
  assign nowLv = {levelC, levelB, levelA};

  assert_level_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    (levelA <= LVL_MAX) && (levelB <= LVL_MAX) && (levelC <= LVL_MAX));

  assert_start_after_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> $past(loadStb, 2));

  assert_step_rule_R6: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |-> (levelDist(nowLv, $past(nowLv)) <= 4'd1));

  assert_hold_on_error_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> $stable(nowLv));

  assert_error_per_period_R6: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |-> $stable(seqError));

endmodule

bind svm7_sequencer svm7_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .levelA      (levelA),
  .levelB      (levelB),
  .levelC      (levelC),
  .periodStart (periodStart),
  .seqError    (seqError),
  .loadStb     (strobe.load)
);

// File: tb/tb_svm7_sequencer.sv
module tb_svm7_sequencer;

  typedef struct {
    logic [8:0] lv;
    bit         first;
    bit         err;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] dA = '0, dB = '0, dZ = '0;
  logic [8:0]  sZa = 9'o222, sV1 = 9'o222, sV2 = 9'o222, sZb = 9'o222;
  logic [2:0]  levelA, levelB, levelC;
  logic        periodStart, seqError;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R8";

  always #2 clk = ~clk;  // 250 MHz

  svm7_sequencer #(.DWELL_W(12)) dut (
    .clk(clk), .rstN(rstN), .dwellA(dA), .dwellB(dB), .dwellZ(dZ),
    .stateZa(sZa), .stateV1(sV1), .stateV2(sV2), .stateZb(sZb),
    .levelA(levelA), .levelB(levelB), .levelC(levelC),
    .periodStart(periodStart), .seqError(seqError)
  );

  // ---------------- behavioural reference model ----------------
  item_t      q[$];
  bit         started;
  logic [8:0] lastLevel;
  logic [8:0] expLv;
  bit         expStart, expErr;
  logic       snapRst = 1'b0;
  logic [11:0] snA, snB, snZ;
  logic [8:0] snZa, snV1, snV2, snZb;

  function automatic logic [8:0] pk(int a, int b, int c);
    logic [2:0] ca = 3'(a), cb = 3'(b), cc = 3'(c);
    return {cc, cb, ca};
  endfunction

  function automatic int dist9(logic [8:0] x, logic [8:0] y);
    int s = 0;
    for (int p = 0; p < 3; p++) begin
      int a = int'(x[3*p +: 3]);
      int b = int'(y[3*p +: 3]);
      s += (a > b) ? a - b : b - a;
    end
    return s;
  endfunction

  task automatic modelLoad();
    int len[7];
    logic [8:0] st[7];
    bit ok = 1;
    bit have = 0;
    bit firstPush = 1;
    logic [8:0] prev = '0;
    int ze = int'(snZ) / 4;
    len = '{ze, int'(snA) / 2, int'(snB) / 2, int'(snZ) - 2 * ze,
            int'(snB) - int'(snB) / 2, int'(snA) - int'(snA) / 2, ze};
    st = '{snZa, snV1, snV2, snZb, snV2, snV1, snZa};
    for (int k = 0; k < 7; k++)
      for (int p = 0; p < 3; p++)
        if (st[k][3*p +: 3] > 3'd4) ok = 0;
    for (int k = 0; k < 7; k++) begin
      if (len[k] > 0) begin
        if (have && dist9(prev, st[k]) > 1) ok = 0;
        prev = st[k];
        have = 1;
      end
    end
    if (!ok) for (int k = 0; k < 7; k++) st[k] = lastLevel;
    if (int'(snA) + int'(snB) + int'(snZ) == 0) begin
      q.push_back('{lv: st[0], first: 1, err: !ok});
    end else begin
      for (int k = 0; k < 7; k++)
        for (int n = 0; n < len[k]; n++) begin
          q.push_back('{lv: st[k], first: firstPush, err: !ok});
          firstPush = 0;
        end
    end
  endtask

  always @(negedge clk) begin
    logic [8:0] act;
    if (!snapRst) begin
      started = 0;
      q.delete();
      lastLevel = 9'o222;
      expLv = 9'o222;
      expStart = 0;
      expErr = 0;
    end else if (!started) begin
      modelLoad();
      started = 1;
      expStart = 0;
    end else begin
      item_t it;
      it = q.pop_front();
      expLv = it.lv;
      expStart = it.first;
      expErr = it.err;
      lastLevel = it.lv;
      if (q.size() == 0) modelLoad();
    end
    act = {levelC, levelB, levelA};
    if (!finished) begin
      compared++;
      if (act !== expLv || periodStart !== expStart || seqError !== expErr) begin
        mismatched++;
        $display("FAIL %s t=%0t: lv=%o start=%b err=%b expected lv=%o start=%b err=%b",
                 curReq, $time, act, periodStart, seqError, expLv, expStart, expErr);
      end
      // R1: only codes 0..4 ever appear
      compared++;
      if (levelA > 3'd4 || levelB > 3'd4 || levelC > 3'd4) begin
        mismatched++;
        $display("FAIL R1 t=%0t: lv=%o expected every code <= 4", $time, act);
      end
    end
    snapRst = rstN;
    snA = dA; snB = dB; snZ = dZ;
    snZa = sZa; snV1 = sV1; snV2 = sV2; snZb = sZb;
  end

  // ---------------- stimulus ----------------
  task automatic setP(int a, int b, int z, logic [8:0] za, logic [8:0] v1,
                      logic [8:0] v2, logic [8:0] zb);
    @(posedge clk); #1;
    dA = 12'(a); dB = 12'(b); dZ = 12'(z);
    sZa = za; sV1 = v1; sV2 = v2; sZb = zb;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [8:0] stepOne(logic [8:0] x);
    int p = int'($urandom % 3);
    int l = int'(x[3*p +: 3]);
    if (l == 4) l--;
    else if (l == 0) l++;
    else l += ($urandom % 2) ? 1 : -1;
    x[3*p +: 3] = 3'(l);
    return x;
  endfunction

  logic [8:0] gZa, gV1, gV2, gZb;

  initial begin
    // R8: reset state
    curReq = "R8";
    waitCyc(4);
    @(posedge clk); #1;
    rstN = 1'b1;
    // R2: nominal sector chain, several identical periods
    curReq = "R2";
    setP(6, 4, 8, pk(3, 0, 0), pk(4, 0, 0), pk(4, 1, 0), pk(4, 1, 1));
    waitCyc(60);
    // R3: odd dwell times, rounding of halves and quarters
    curReq = "R3";
    setP(5, 3, 7, pk(2, 2, 1), pk(2, 2, 2), pk(3, 2, 2), pk(3, 3, 2));
    waitCyc(60);
    // R4: empty zero segments are skipped
    curReq = "R4";
    setP(4, 6, 0, pk(1, 1, 1), pk(2, 1, 1), pk(2, 2, 1), pk(2, 2, 2));
    waitCyc(40);
    setP(2, 2, 1, pk(1, 1, 1), pk(2, 1, 1), pk(2, 2, 1), pk(2, 2, 2));
    waitCyc(30);
    // R6: code above 4 in a state
    curReq = "R6";
    setP(3, 3, 4, pk(3, 0, 0), pk(5, 0, 0), pk(4, 1, 0), pk(4, 1, 1));
    waitCyc(30);
    // R6: two-phase jump between active vectors
    setP(3, 3, 4, pk(3, 0, 0), pk(4, 0, 0), pk(4, 1, 1), pk(4, 1, 1));
    waitCyc(30);
    // R6: empty first V1 half makes Za -> V2 a two-level step
    setP(1, 4, 8, pk(3, 0, 0), pk(4, 0, 0), pk(4, 1, 0), pk(4, 1, 1));
    waitCyc(30);
    // R7: all dwell times zero, one-tick periods
    curReq = "R7";
    setP(0, 0, 0, pk(0, 4, 2), pk(1, 4, 2), pk(1, 3, 2), pk(1, 3, 3));
    waitCyc(20);
    // R5: random parameters changed at arbitrary times mid-period
    curReq = "R5";
    for (int i = 0; i < 600; i++) begin
      gZa = pk(int'($urandom % 5), int'($urandom % 5), int'($urandom % 5));
      gV1 = stepOne(gZa);
      gV2 = stepOne(gV1);
      gZb = stepOne(gV2);
      if ($urandom % 8 == 0) gV2 = pk(int'($urandom % 8), 0, 4);
      setP(int'($urandom % 12), int'($urandom % 12), int'($urandom % 16),
           gZa, gV1, gV2, gZb);
      waitCyc(int'($urandom % 20));
    end
    waitCyc(40);
    @(negedge clk);
    #1;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule